// File: doc/BRIEF.md
# Pixel-to-Cell Display Mapper

This block sits beside a raster timing generator and turns each requested screen coordinate into a colour. The coordinate is already adjusted for zoom and pan. The block splits it into a cell index and an offset inside that cell, then issues a read of the memory word that holds the cell. Each memory word holds a column of several vertically adjacent cells, one per lane. When the word returns, the block picks out the addressed cell's two-bit state and registers a 24-bit colour.

Two kinds of pixel override the cell state. Pixels on the first row or first column of a cell are drawn as a grey border. Pixels that fall outside the parameterised grid are drawn purple. Both decisions are made when the address is issued and travel through a delay line matched to the read latency, so they reach the colour stage together with the returned word. The cell size is a power of two, which makes cell index and offset plain bit slices of the coordinate. One coordinate is accepted every cycle and results stream out in order.

Top module: `cell_display_mapper`

## Requirements
- R1: While rst_ni is low, colour_o is 24'h000000 and mem_raddr_o is 0.
- R2: For an in-grid pixel, col = x >> CELL_LOG2 and row = y >> CELL_LOG2. mem_raddr_o equals (row / LANES) * GRID_COLS + col one clock edge after the coordinate is sampled.
- R3: For a pixel with col >= GRID_COLS or row >= GRID_ROWS, mem_raddr_o is 0 one clock edge after the coordinate is sampled.
- R4: The cell state is bits [2*(row % LANES) +: 2] of mem_rdata_i, taken RD_LAT cycles after the address is issued.
- R5: A non-border in-grid pixel is coloured by state: 0 gives 24'h000000, 1 gives 24'h0000FF, 2 gives 24'hFF0000, 3 gives 24'hFFFF00.
- R6: An in-grid pixel whose x or y offset inside its cell is zero is coloured 24'h808080, whatever the cell state.
- R7: An out-of-grid pixel is coloured 24'h800080. This takes priority over the border rule.
- R8: The colour for a coordinate sampled at clock edge k is on colour_o after edge k + RD_LAT + 2. A new coordinate is accepted every cycle, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| px_x_i | input | COORD_W | Mapped pixel x coordinate |
| px_y_i | input | COORD_W | Mapped pixel y coordinate |
| mem_raddr_o | output | ADDR_W | Cell memory read address |
| mem_rdata_i | input | 2*LANES | Memory word, RD_LAT cycles after its address |
| colour_o | output | 24 | Pixel colour |

## Verification
The address is due one edge after the coordinate is sampled. The colour is due RD_LAT + 2 edges after sampling: one edge for the address register, RD_LAT edges for the memory, and one edge for the colour register. The bench drives a coordinate on each falling edge. At the same falling edge it checks the address against the coordinate driven one cycle earlier and the colour against the coordinate three cycles earlier, which matches the default one-cycle memory model. Expected results are held in a queue in the order they were requested. A raster sweep, random coordinates and grid-edge coordinates all pass through this same pipeline.

// File: rtl/dm_pkg.sv
package dm_pkg;
  typedef logic [23:0] rgb_t;
  localparam rgb_t RGB_BLACK  = 24'h000000;
  localparam rgb_t RGB_BLUE   = 24'h0000FF;
  localparam rgb_t RGB_RED    = 24'hFF0000;
  localparam rgb_t RGB_YELLOW = 24'hFFFF00;
  localparam rgb_t RGB_GREY   = 24'h808080;
  localparam rgb_t RGB_PURPLE = 24'h800080;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_HEAD  = 2'd1,
    ST_TAIL  = 2'd2,
    ST_WIRE  = 2'd3
  } cell_st_e;

  function automatic rgb_t state_rgb(input logic [1:0] st);
    case (cell_st_e'(st))
      ST_EMPTY: state_rgb = RGB_BLACK;
      ST_HEAD:  state_rgb = RGB_BLUE;
      ST_TAIL:  state_rgb = RGB_RED;
      default:  state_rgb = RGB_YELLOW;
    endcase
  endfunction
endpackage

// File: rtl/dm_addr_gen.sv
module dm_addr_gen #(
  parameter int COORD_W   = 11,
  parameter int CELL_LOG2 = 3,
  parameter int GRID_COLS = 20,
  parameter int GRID_ROWS = 12,
  parameter int LANE_LOG2 = 2,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [COORD_W-1:0]   px_x_i,
  input  logic [COORD_W-1:0]   px_y_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [LANE_LOG2-1:0] lane_o,
  output logic                 border_o,
  output logic                 outside_o
);
  localparam int IDX_W = COORD_W - CELL_LOG2;

  logic [IDX_W-1:0]           col_idx, row_idx;
  logic [IDX_W-LANE_LOG2-1:0] grp_idx;
  logic                       in_grid, on_edge;
  logic [ADDR_W-1:0]          addr_d;

  assign col_idx = px_x_i[COORD_W-1:CELL_LOG2];
  assign row_idx = px_y_i[COORD_W-1:CELL_LOG2];
  assign grp_idx = row_idx[IDX_W-1:LANE_LOG2];
  assign in_grid = (col_idx < IDX_W'(GRID_COLS)) && (row_idx < IDX_W'(GRID_ROWS));
  assign on_edge = (px_x_i[CELL_LOG2-1:0] == '0) || (px_y_i[CELL_LOG2-1:0] == '0);

  // out-of-grid reads are parked at 0; the data is discarded downstream
  always_comb begin
    addr_d = '0;
    if (in_grid) addr_d = ADDR_W'(grp_idx) * ADDR_W'(GRID_COLS) + ADDR_W'(col_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o    <= '0;
      lane_o    <= '0;
      border_o  <= 1'b0;
      outside_o <= 1'b0;
    end else begin
      addr_o    <= addr_d;
      lane_o    <= row_idx[LANE_LOG2-1:0];
      border_o  <= on_edge;
      outside_o <= !in_grid;
    end
  end
endmodule

// File: rtl/dm_delay.sv
module dm_delay #(
  parameter int W     = 4,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage [DEPTH+1];

  assign stage[0] = d_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage[i+1] <= '0;
      else         stage[i+1] <= stage[i];
    end
  end

  assign q_o = stage[DEPTH];
endmodule

// File: rtl/dm_colour.sv
module dm_colour
  import dm_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_LOG2 = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*LANES-1:0]   word_i,
  input  logic [LANE_LOG2-1:0] lane_i,
  input  logic                 border_i,
  input  logic                 outside_i,
  output rgb_t                 colour_o
);
  logic [1:0] st;
  rgb_t       colour_d;

  assign st = word_i[2*lane_i +: 2];

  always_comb begin
    if (outside_i)     colour_d = RGB_PURPLE;
    else if (border_i) colour_d = RGB_GREY;
    else               colour_d = state_rgb(st);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) colour_o <= RGB_BLACK;
    else         colour_o <= colour_d;
  end
endmodule

// File: rtl/cell_display_mapper.sv
module cell_display_mapper #(
  parameter int COORD_W   = 11,
  parameter int CELL_LOG2 = 3,
  parameter int GRID_COLS = 20,
  parameter int GRID_ROWS = 12,
  parameter int LANES     = 4,
  parameter int RD_LAT    = 1,
  localparam int LANE_LOG2 = $clog2(LANES),
  localparam int GROUPS    = (GRID_ROWS + LANES - 1) / LANES,
  localparam int ADDR_W    = $clog2(GRID_COLS * GROUPS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [COORD_W-1:0] px_x_i,
  input  logic [COORD_W-1:0] px_y_i,
  output logic [ADDR_W-1:0]  mem_raddr_o,
  input  logic [2*LANES-1:0] mem_rdata_i,
  output logic [23:0]        colour_o
);
  localparam int SIDE_W = LANE_LOG2 + 2;

  logic [LANE_LOG2-1:0] lane_a, lane_d;
  logic                 border_a, border_d, outside_a, outside_d;

  dm_addr_gen #(
    .COORD_W(COORD_W), .CELL_LOG2(CELL_LOG2), .GRID_COLS(GRID_COLS),
    .GRID_ROWS(GRID_ROWS), .LANE_LOG2(LANE_LOG2), .ADDR_W(ADDR_W)
  ) u_addr (
    .clk_i, .rst_ni, .px_x_i, .px_y_i,
    .addr_o(mem_raddr_o), .lane_o(lane_a), .border_o(border_a), .outside_o(outside_a)
  );

  // side info follows the word through the memory latency
  dm_delay #(.W(SIDE_W), .DEPTH(RD_LAT)) u_side (
    .clk_i, .rst_ni,
    .d_i({lane_a, border_a, outside_a}),
    .q_o({lane_d, border_d, outside_d})
  );

  dm_colour #(.LANES(LANES), .LANE_LOG2(LANE_LOG2)) u_colour (
    .clk_i, .rst_ni, .word_i(mem_rdata_i), .lane_i(lane_d),
    .border_i(border_d), .outside_i(outside_d), .colour_o
  );
endmodule

// File: rtl/dm_checker.sv
module dm_checker
  import dm_pkg::*;
#(
  parameter int COORD_W   = 11,
  parameter int CELL_LOG2 = 3,
  parameter int GRID_COLS = 20,
  parameter int GRID_ROWS = 12,
  parameter int LANES     = 4,
  parameter int RD_LAT    = 1,
  parameter int ADDR_W    = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [COORD_W-1:0] px_x_i,
  input logic [COORD_W-1:0] px_y_i,
  input logic [ADDR_W-1:0]  mem_raddr_o,
  input logic [2*LANES-1:0] mem_rdata_i,
  input logic [23:0]        colour_o
);
  localparam int L = RD_LAT + 1;
  localparam int CELL = 1 << CELL_LOG2;

  int cx, cy, ex_addr, ex_lane;
  logic ex_out, ex_edge;
  assign cx      = int'(px_x_i) / CELL;
  assign cy      = int'(px_y_i) / CELL;
  assign ex_out  = (cx >= GRID_COLS) || (cy >= GRID_ROWS);
  assign ex_edge = (int'(px_x_i) % CELL == 0) || (int'(px_y_i) % CELL == 0);
  assign ex_lane = cy % LANES;
  assign ex_addr = ex_out ? 0 : (cy / LANES) * GRID_COLS + cx;

  logic primed;
  logic v_q [L+1];
  logic o_q [L+1];
  logic e_q [L+1];
  int   l_q [L+1];
  logic [2*LANES-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed  <= 1'b0;
      rdata_q <= '0;
      for (int i = 0; i <= L; i++) begin
        v_q[i] <= 1'b0; o_q[i] <= 1'b0; e_q[i] <= 1'b0; l_q[i] <= 0;
      end
    end else begin
      primed  <= 1'b1;
      rdata_q <= mem_rdata_i;
      v_q[0] <= 1'b1; o_q[0] <= ex_out; e_q[0] <= ex_edge; l_q[0] <= ex_lane;
      for (int i = 1; i <= L; i++) begin
        v_q[i] <= v_q[i-1]; o_q[i] <= o_q[i-1]; e_q[i] <= e_q[i-1]; l_q[i] <= l_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_IDLE: assert (colour_o == 24'h0 && mem_raddr_o == '0); // R1
  end

  AST_ADDR_IN_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && !$past(ex_out) |-> int'(mem_raddr_o) == $past(ex_addr)); // R2
  AST_ADDR_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(ex_out) |-> mem_raddr_o == '0); // R3
  AST_OUTSIDE_PURPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q[L] && o_q[L] |-> colour_o == RGB_PURPLE); // R7
  AST_BORDER_GREY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q[L] && !o_q[L] && e_q[L] |-> colour_o == RGB_GREY); // R6
  AST_STATE_COLOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q[L] && !o_q[L] && !e_q[L] |-> colour_o == state_rgb(rdata_q[2*l_q[L] +: 2])); // R5
endmodule

bind cell_display_mapper dm_checker #(
  .COORD_W(COORD_W), .CELL_LOG2(CELL_LOG2), .GRID_COLS(GRID_COLS),
  .GRID_ROWS(GRID_ROWS), .LANES(LANES), .RD_LAT(RD_LAT), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/cell_display_mapper_bench.sv
`timescale 1ns/1ps
module cell_display_mapper_bench;
  localparam int COLS = 20, ROWS = 12, LANES = 4, CELL = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] px_x_i = '0, px_y_i = '0;
  logic [5:0]  mem_raddr_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [23:0] colour_o;

  int tests = 0, fails = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  int          prev_addr;
  bit          have_prev = 0;
  string       prev_tag;

  always #2 clk_i = ~clk_i;

  cell_display_mapper u_cell_display_mapper (.*);

  function automatic int cell_state(int c, int r);
    return (c + 3 * r + c / 3) % 4;
  endfunction

  function automatic logic [7:0] word_at(int a);
    logic [7:0] w = '0;
    for (int l = 0; l < LANES; l++) w[2*l +: 2] = 2'(cell_state(a % COLS, (a / COLS) * LANES + l));
    return w;
  endfunction

  // one-cycle memory
  always @(posedge clk_i) mem_rdata_i <= word_at(int'(mem_raddr_o));

  function automatic logic [23:0] rgb_of(int s);
    case (s)
      0: return 24'h000000;
      1: return 24'h0000FF;
      2: return 24'hFF0000;
      default: return 24'hFFFF00;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int x, input int y);
    int c, r;
    logic [23:0] e;
    string t;
    @(negedge clk_i);
    if (have_prev) check(int'(mem_raddr_o) == prev_addr, prev_tag, int'(mem_raddr_o), prev_addr);
    if (exp_q.size() == 3) begin // R8: three edges with RD_LAT=1
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(colour_o == e, t, int'(colour_o), int'(e));
    end
    px_x_i = 11'(x);
    px_y_i = 11'(y);
    c = x / CELL;
    r = y / CELL;
    if (c >= COLS || r >= ROWS) begin
      e = 24'h800080; t = "R7 R8 colour";
      prev_addr = 0; prev_tag = "R3 address";
    end else begin
      prev_addr = (r / LANES) * COLS + c; prev_tag = "R2 address";
      if (x % CELL == 0 || y % CELL == 0) begin e = 24'h808080; t = "R6 R8 colour"; end
      else begin e = rgb_of(cell_state(c, r)); t = "R4 R5 R8 colour"; end
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
    have_prev = 1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(colour_o == 24'h0, "R1 reset colour", int'(colour_o), 0);
    check(mem_raddr_o == '0, "R1 reset address", int'(mem_raddr_o), 0);
    rst_ni = 1'b1;
    // raster sweep over and past the grid
    for (int y = 0; y < ROWS * CELL + 8; y++)
      for (int x = 0; x < COLS * CELL + 16; x++) step(x, y);
    // random coordinates
    for (int i = 0; i < 3000; i++) step(int'($urandom_range(0, 300)), int'($urandom_range(0, 200)));
    // grid corners and the coordinate limit
    step(COLS * CELL - 1, ROWS * CELL - 1);
    step(COLS * CELL, ROWS * CELL - 1);
    step(COLS * CELL - 1, ROWS * CELL);
    step(COLS * CELL, 0);
    step(2047, 2047);
    step(1, 1);
    step(CELL + 1, CELL * 5 + 3);
    for (int i = 0; i < 4; i++) step(3, 3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule